// File: doc/BRIEF.md
# Deep-Standby Sequencer with Settled Wake-Up

This block decides whether a sleep request from the processor turns into deep standby. Once in standby, it shuts off the oscillator and gates the processor and peripheral clocks. It brings the chip back on one of two events: a qualified external interrupt, or the external reset pin.

For an interrupt wake, the oscillator is turned back on first. The block then counts a programmable settling interval before it releases the clocks. After that it raises a one-cycle exception strobe so that interrupt handling can start.

The reset-pin path is different. The clocks come back at once, with no settling count. A reset exception strobe follows when the pin is released.

The counting clock `clk` is taken to be the restarted oscillator's output, seen as a free-running reference. The reset pin is expected to arrive already synchronised to `clk`.

Top module: `stby_wake_ctrl`

## Requirements
- R1: A sleep strobe moves the block from running to standby only when `cfgStandbySel`=1, `cfgLowSpeedSel`=0 and `cfgWdtPrescaleSel`=0. For every other combination, `oscEnable` and `clkEnable` stay 1.
- R2: In standby, `oscEnable` and `clkEnable` are both 0, and they stay 0 until a wake event.
- R3: `nmiReq` wakes the block from standby whatever the values of `cpuMasked`, `irqEnable` and `irqXferSrc`.
- R4: Line i of `irqReq` wakes the block only when `irqEnable[i]`=1, `irqXferSrc[i]`=0 and `cpuMasked`=0. A request on line i does not count through another line's enable bit.
- R5: After an interrupt wake, `oscEnable` is 1 and `clkEnable` is 0 for exactly 2^(SETTLE_BASE_LOG2+sel) cycles, where sel is `cfgSettleSel`. Then `clkEnable` returns to 1.
- R6: `wakeStrobe` is high for one cycle, in the first cycle in which `clkEnable` is 1 again. The block then stays running.
- R7: While `resetPinN` is sampled 0, `oscEnable` and `clkEnable` are both 1 from the next cycle on, whatever the state.
- R8: When `resetPinN` returns to 1, `resetExcStrobe` pulses for one cycle in the following cycle, with no settling count. The block then runs normally.
- R9: A reset-pin assertion in the same cycle as an interrupt wake takes the reset path, so `wakeStrobe` never fires. A reset-pin assertion during settling aborts the count.
- R10: The settling selector is captured while in standby. Changing `cfgSettleSel` during settling does not change the interval.
- R11: After `rstN` is released, the block is running: `oscEnable`=1, `clkEnable`=1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (restarted oscillator) |
| rstN | input | 1 | Asynchronous system reset, active low |
| sleepStrobe | input | 1 | One-cycle pulse when the sleep instruction executes |
| cfgStandbySel | input | 1 | Standby select; must be 1 for entry |
| cfgLowSpeedSel | input | 1 | Low-speed select; must be 0 for entry |
| cfgWdtPrescaleSel | input | 1 | Watchdog prescaler select; must be 0 for entry |
| cfgSettleSel | input | 3 | Settling interval selector |
| nmiReq | input | 1 | Non-maskable interrupt request |
| irqReq | input | 6 | External interrupt request lines |
| irqEnable | input | 6 | Per-line interrupt enable |
| irqXferSrc | input | 6 | Per-line flag: line is a transfer activation source |
| cpuMasked | input | 1 | Processor interrupt mask flag |
| resetPinN | input | 1 | External reset pin, active low, synchronised |
| oscEnable | output | 1 | Oscillator enable |
| clkEnable | output | 1 | Processor and peripheral clock enable |
| wakeStrobe | output | 1 | One-cycle interrupt-exception strobe after settling |
| resetExcStrobe | output | 1 | One-cycle reset-exception strobe after pin release |

## Verification
The bench measures the settling interval to the exact cycle for several selector values. An off-by-one counter would show up as an interval of 2^n±1 cycles, and a selector read live would lengthen the interval when the selector changes mid-settle.

It tries every entry-bit combination. A loose entry decode would let the oscillator drop on a mismatched combination.

It checks each IRQ blocking condition separately: a missing enable, the processor mask, a transfer-source designation and a cross-line enable. A wrong qualifier would wake the block from one of these.

It asserts the reset pin in three situations: from standby, during settling, and in the same cycle as an IRQ. A design that let the interrupt path win would emit `wakeStrobe` or keep the clocks gated after the pin is released.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_STANDBY, ST_SETTLE, ST_WAKE, ST_PINHOLD, ST_PINEXC
  } stbyState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic latchSel;  // capture settling selector
    logic cntRun;    // settle counter advances
  } dpCtrl_t;
endpackage

// File: rtl/stby_datapath.sv
module stby_datapath
  import stby_pkg::*;
#(
  parameter int NUM_IRQ          = 6,
  parameter int SEL_W            = 3,
  parameter int SETTLE_BASE_LOG2 = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtrl_t            ctrl,
  input  logic [SEL_W-1:0]   settleSel,
  input  logic               nmiReq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic [NUM_IRQ-1:0] irqXferSrc,
  input  logic               cpuMasked,
  output logic               wakeReq,
  output logic               settleDone
);
  localparam int CNT_W = SETTLE_BASE_LOG2 + (1 << SEL_W) - 1;

  logic [NUM_IRQ-1:0] lineOk;
  logic [SEL_W-1:0]   selLatch;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W:0]     target;
  logic [CNT_W-1:0]   settleLast;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_qual
    assign lineOk[i] = irqReq[i] & irqEnable[i] & ~irqXferSrc[i];
  end

  assign wakeReq = nmiReq | ((|lineOk) & ~cpuMasked);

  always_comb begin
    target     = (CNT_W+1)'(1) << (SETTLE_BASE_LOG2 + int'(selLatch));
    settleLast = CNT_W'(target - 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selLatch <= '0;
      cnt      <= '0;
    end else begin
      if (ctrl.latchSel) selLatch <= settleSel;
      if (ctrl.cntRun) cnt <= cnt + 1'b1;
      else             cnt <= '0;
    end
  end

  assign settleDone = ctrl.cntRun && (cnt == settleLast);

  // R10: selector frozen while settling
  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cntRun |=> $stable(selLatch));
  // R4: processor mask blocks every IRQ line
  p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!nmiReq && cpuMasked) |-> !wakeReq);
  // R3: NMI always qualifies
  p_nmi_wakes_r3: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> wakeReq);
  // R5: counter never passes the selected limit
  p_count_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.cntRun |-> (cnt <= settleLast));
endmodule

// File: rtl/stby_control.sv
module stby_control
  import stby_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sleepStrobe,
  input  logic    standbySel,
  input  logic    lowSpeedSel,
  input  logic    wdtPrescaleSel,
  input  logic    wakeReq,
  input  logic    settleDone,
  input  logic    resetPinN,
  output dpCtrl_t ctrl,
  output logic    oscEnable,
  output logic    clkEnable,
  output logic    wakeStrobe,
  output logic    resetExcStrobe
);
  stbyState_e state, nextState;
  logic entryOk;

  assign entryOk = sleepStrobe & standbySel & ~lowSpeedSel & ~wdtPrescaleSel;

  always_comb begin
    nextState = state;
    if (!resetPinN) nextState = ST_PINHOLD;
    else begin
      unique case (state)
        ST_RUN:     if (entryOk) nextState = ST_STANDBY;
        ST_STANDBY: if (wakeReq) nextState = ST_SETTLE;
        ST_SETTLE:  if (settleDone) nextState = ST_WAKE;
        ST_WAKE:    nextState = ST_RUN;
        ST_PINHOLD: nextState = ST_PINEXC;
        ST_PINEXC:  nextState = ST_RUN;
        default:    nextState = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  assign ctrl.latchSel  = (state == ST_STANDBY);
  assign ctrl.cntRun    = (state == ST_SETTLE);
  assign oscEnable      = (state != ST_STANDBY);
  assign clkEnable      = (state != ST_STANDBY) && (state != ST_SETTLE);
  assign wakeStrobe     = (state == ST_WAKE);
  assign resetExcStrobe = (state == ST_PINEXC);

  // R1: standby is only reached from a qualified sleep request
  p_entry_qualified_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && $past(state) == ST_RUN)
      |-> $past(sleepStrobe && standbySel && !lowSpeedSel && !wdtPrescaleSel));
  // R5: settling holds until the counter reports done
  p_settle_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE && !settleDone && resetPinN) |=> (state == ST_SETTLE));
  // R6: wake strobe lasts one cycle, clocks stay on after it
  p_wake_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeStrobe |=> (!wakeStrobe && clkEnable));
  // R7/R9: pin low forces clocks on next cycle, never an interrupt wake
  p_pin_clocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    !resetPinN |=> (oscEnable && clkEnable && !wakeStrobe));
  // R8: reset exception follows the pin hold phase
  p_reset_exc_r8: assert property (@(posedge clk) disable iff (!rstN)
    resetExcStrobe |-> ($past(state) == ST_PINHOLD));
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
  import stby_pkg::*;
#(
  parameter int NUM_IRQ          = 6,
  parameter int SEL_W            = 3,
  parameter int SETTLE_BASE_LOG2 = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sleepStrobe,
  input  logic               cfgStandbySel,
  input  logic               cfgLowSpeedSel,
  input  logic               cfgWdtPrescaleSel,
  input  logic [SEL_W-1:0]   cfgSettleSel,
  input  logic               nmiReq,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic [NUM_IRQ-1:0] irqEnable,
  input  logic [NUM_IRQ-1:0] irqXferSrc,
  input  logic               cpuMasked,
  input  logic               resetPinN,
  output logic               oscEnable,
  output logic               clkEnable,
  output logic               wakeStrobe,
  output logic               resetExcStrobe
);
  dpCtrl_t ctrl;
  logic    wakeReq;
  logic    settleDone;

  stby_control u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .sleepStrobe    (sleepStrobe),
    .standbySel     (cfgStandbySel),
    .lowSpeedSel    (cfgLowSpeedSel),
    .wdtPrescaleSel (cfgWdtPrescaleSel),
    .wakeReq        (wakeReq),
    .settleDone     (settleDone),
    .resetPinN      (resetPinN),
    .ctrl           (ctrl),
    .oscEnable      (oscEnable),
    .clkEnable      (clkEnable),
    .wakeStrobe     (wakeStrobe),
    .resetExcStrobe (resetExcStrobe)
  );

  stby_datapath #(
    .NUM_IRQ          (NUM_IRQ),
    .SEL_W            (SEL_W),
    .SETTLE_BASE_LOG2 (SETTLE_BASE_LOG2)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .settleSel  (cfgSettleSel),
    .nmiReq     (nmiReq),
    .irqReq     (irqReq),
    .irqEnable  (irqEnable),
    .irqXferSrc (irqXferSrc),
    .cpuMasked  (cpuMasked),
    .wakeReq    (wakeReq),
    .settleDone (settleDone)
  );
endmodule

// File: tb/tb_stby_wake_ctrl.sv
module tb_stby_wake_ctrl;
  localparam int BASE = 2;

  logic clk = 0, rstN = 0;
  logic sleepStrobe = 0, cfgStandbySel = 0, cfgLowSpeedSel = 0, cfgWdtPrescaleSel = 0;
  logic [2:0] cfgSettleSel = 0;
  logic nmiReq = 0, cpuMasked = 0, resetPinN = 1;
  logic [5:0] irqReq = 0, irqEnable = 0, irqXferSrc = 0;
  logic oscEnable, clkEnable, wakeStrobe, resetExcStrobe;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  stby_wake_ctrl #(.SETTLE_BASE_LOG2(BASE)) dut (
    .clk(clk), .rstN(rstN), .sleepStrobe(sleepStrobe),
    .cfgStandbySel(cfgStandbySel), .cfgLowSpeedSel(cfgLowSpeedSel),
    .cfgWdtPrescaleSel(cfgWdtPrescaleSel), .cfgSettleSel(cfgSettleSel),
    .nmiReq(nmiReq), .irqReq(irqReq), .irqEnable(irqEnable),
    .irqXferSrc(irqXferSrc), .cpuMasked(cpuMasked), .resetPinN(resetPinN),
    .oscEnable(oscEnable), .clkEnable(clkEnable),
    .wakeStrobe(wakeStrobe), .resetExcStrobe(resetExcStrobe));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic goStandby(input logic [2:0] sel);
    @(negedge clk);
    cfgStandbySel = 1; cfgLowSpeedSel = 0; cfgWdtPrescaleSel = 0;
    cfgSettleSel = sel; sleepStrobe = 1;
    @(negedge clk);
    sleepStrobe = 0;
    chk("R2 osc off in standby", oscEnable, 0);
    chk("R2 clk off in standby", clkEnable, 0);
  endtask

  // Caller has just driven a wake input at a negedge.
  task automatic measure(input string req, output int n);
    @(negedge clk);
    nmiReq = 0; irqReq = 0;
    chk({req, " osc on during settle"}, oscEnable, 1);
    n = 0;
    while (!clkEnable && n < 3000) begin
      n++;
      @(negedge clk);
    end
    chk("R6 wake strobe with clocks back", wakeStrobe, 1);
    @(negedge clk);
    chk("R6 wake strobe single cycle", wakeStrobe, 0);
    chk("R6 clocks stay on", clkEnable, 1);
  endtask

  task automatic tReset;
    chk("R11 osc after reset", oscEnable, 1);
    chk("R11 clk after reset", clkEnable, 1);
    chk("R11 wake strobe idle", wakeStrobe, 0);
    chk("R11 reset exc idle", resetExcStrobe, 0);
  endtask

  task automatic tEntryCombos;
    int n;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      cfgStandbySel = c[2]; cfgLowSpeedSel = c[1]; cfgWdtPrescaleSel = c[0];
      cfgSettleSel = 0; sleepStrobe = 1;
      @(negedge clk);
      sleepStrobe = 0;
      chk($sformatf("R1 combo %0d osc", c), oscEnable, (c == 4) ? 0 : 1);
      chk($sformatf("R1 combo %0d clk", c), clkEnable, (c == 4) ? 0 : 1);
      if (c == 4) begin
        nmiReq = 1;
        measure("R3", n);
      end
    end
  endtask

  task automatic tSettle(input logic [2:0] sel);
    int n;
    goStandby(sel);
    irqEnable = 6'b000001; irqReq = 6'b000001;
    measure("R5", n);
    chk($sformatf("R5 settle length sel %0d", sel), n, 1 << (BASE + sel));
    irqEnable = 0;
  endtask

  task automatic tIrqQual;
    int n;
    goStandby(0);
    // no enable
    irqReq = 6'b000100; @(negedge clk); irqReq = 0; @(negedge clk);
    chk("R4 disabled line ignored", oscEnable, 0);
    // cross-line enable
    irqEnable = 6'b000100; irqReq = 6'b001000; @(negedge clk); irqReq = 0; @(negedge clk);
    chk("R4 other line enable ignored", oscEnable, 0);
    // cpu mask
    cpuMasked = 1; irqReq = 6'b000100; @(negedge clk); irqReq = 0; cpuMasked = 0; @(negedge clk);
    chk("R4 masked line ignored", oscEnable, 0);
    // transfer source
    irqXferSrc = 6'b000100; irqReq = 6'b000100; @(negedge clk); irqReq = 0; irqXferSrc = 0; @(negedge clk);
    chk("R4 transfer source ignored", oscEnable, 0);
    chk("R2 clocks still off", clkEnable, 0);
    // valid wake on line 5
    irqEnable = 6'b100000; irqReq = 6'b100000;
    measure("R4", n);
    chk("R4 valid line settle", n, 1 << BASE);
    irqEnable = 0;
  endtask

  task automatic tNmi;
    int n;
    goStandby(1);
    cpuMasked = 1; irqEnable = 0; irqXferSrc = 6'h3f; nmiReq = 1;
    measure("R3", n);
    chk("R3 nmi settle length", n, 1 << (BASE + 1));
    cpuMasked = 0; irqXferSrc = 0;
  endtask

  task automatic tPinWake;
    goStandby(2);
    resetPinN = 0;
    @(negedge clk);
    chk("R7 osc on at pin low", oscEnable, 1);
    chk("R7 clk on at pin low", clkEnable, 1);
    repeat (3) @(negedge clk);
    chk("R8 no exc while pin low", resetExcStrobe, 0);
    resetPinN = 1;
    @(negedge clk);
    chk("R8 reset exc after release", resetExcStrobe, 1);
    @(negedge clk);
    chk("R8 reset exc single cycle", resetExcStrobe, 0);
    chk("R8 running after release", clkEnable, 1);
  endtask

  task automatic tPinAbort;
    int n;
    int seen = 0;
    goStandby(3);
    nmiReq = 1;
    @(negedge clk); nmiReq = 0;
    repeat (4) @(negedge clk);
    chk("R9 still settling", clkEnable, 0);
    resetPinN = 0;
    @(negedge clk);
    chk("R9 abort gives clocks", clkEnable, 1);
    resetPinN = 1;
    @(negedge clk);
    chk("R9 reset exc after abort", resetExcStrobe, 1);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (wakeStrobe) seen++;
    end
    chk("R9 aborted count never wakes", seen, 0);
    // fresh full count afterwards
    goStandby(1);
    nmiReq = 1;
    measure("R9", n);
    chk("R9 counter restarts", n, 1 << (BASE + 1));
  endtask

  task automatic tSameCycle;
    int seen = 0;
    goStandby(0);
    irqEnable = 6'b000010; irqReq = 6'b000010; resetPinN = 0;
    @(negedge clk);
    irqReq = 0;
    chk("R9 reset wins clk", clkEnable, 1);
    resetPinN = 1;
    @(negedge clk);
    chk("R9 reset wins exc", resetExcStrobe, 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (wakeStrobe) seen++;
    end
    chk("R9 no interrupt wake", seen, 0);
    irqEnable = 0;
  endtask

  task automatic tSelChange;
    int n;
    goStandby(1);
    nmiReq = 1;
    @(negedge clk);
    nmiReq = 0;
    cfgSettleSel = 7;
    n = 1;
    while (!clkEnable && n < 3000) begin
      @(negedge clk);
      if (!clkEnable) n++;
    end
    chk("R10 selector change ignored", n, 1 << (BASE + 1));
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tEntryCombos();
    tSettle(0);
    tSettle(3);
    tSettle(7);
    tIrqQual();
    tNmi();
    tPinWake();
    tPinAbort();
    tSameCycle();
    tSelChange();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule